// File: doc/BRIEF.md
# Binary and Packed-BCD Add/Subtract Unit

This block is an 8-bit arithmetic unit that adds with a carry or subtracts with a borrow. One input picks between plain two's-complement binary arithmetic and packed decimal arithmetic. In decimal mode each byte holds two decimal digits, one per nibble, and the result is corrected back into the same two-digit form. A single carry bit acts as the ninth bit of the result. On an add it is the carry out. On a subtract it is set when no borrow was needed and clear when one was.

Each operation is presented with a one-cycle valid strobe. The result and the four flags (carry, overflow, negative, zero) are registered and appear one clock later together with an output strobe. The outputs keep their value until the next strobed operation. The block does not check whether decimal operands are valid, and it does no instruction sequencing.

Top module: `decadd_unit`

## Requirements
- R1: While reset is held and just after it is released, `out_valid`, `sum`, `c_out`, `v_out`, `n_out` and `z_out` are all 0.
- R2: An operation strobed with `in_valid` shows up on the outputs, with `out_valid` high, one clock later. In a cycle after one where `in_valid` was low, `out_valid` is low and the result and flags hold their previous values whatever the other inputs do.
- R3: Binary add (`decimal`=0, `subtract`=0): `sum` = (A + B + `carry_in`) mod 256, and `c_out` = 1 exactly when A + B + `carry_in` > 255.
- R4: Binary subtract (`decimal`=0, `subtract`=1): `sum` = (A − B − (1 − `carry_in`)) mod 256, and `c_out` = 1 exactly when that difference is not negative (no borrow).
- R5: `v_out` flags signed overflow of the unadjusted binary operation in both modes. The operands are read as −128..127 (0x80..0xFF meaning −128..−1), and V is set when the true signed add or subtract result, including the carry/borrow term, lies outside −128..127.
- R6: `n_out` equals bit 7 of the final `sum`, and `z_out` is 1 exactly when the final `sum` is 0x00. This holds in both modes, after any decimal correction. For example, binary 0x02 − 0x85 with `carry_in`=1 gives 0x7D with N=0.
- R7: Decimal add (`decimal`=1, `subtract`=0). Bits 7:4 hold the tens digit and bits 3:0 the units digit. For operands in 0x00..0x99, `sum` is the packed form of (a + b + `carry_in`) mod 100, and `c_out` = 1 exactly when a + b + `carry_in` > 99. So 0x55 + 0x27 gives 0x82 with C=0, and 0x99 + 0x01 gives 0x00 with C=1.
- R8: Decimal subtract (`decimal`=1, `subtract`=1), with the same digit layout: `sum` is the packed form of (a − b − (1 − `carry_in`)) mod 100, and `c_out` = 1 exactly when that difference is not negative.
- R9: In decimal mode with both operands in 0x00..0x99, both digits of `sum` are in 0..9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 8 | First operand (minuend on subtract) |
| op_b | input | 8 | Second operand (subtrahend on subtract) |
| carry_in | input | 1 | Carry in; on subtract, 1 means no borrow in |
| subtract | input | 1 | 1 selects subtract, 0 selects add |
| decimal | input | 1 | 1 selects packed-BCD mode |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| sum | output | 8 | Registered result |
| c_out | output | 1 | Carry out / no-borrow |
| v_out | output | 1 | Signed overflow |
| n_out | output | 1 | Bit 7 of the result |
| z_out | output | 1 | Result is zero |

## Verification
Decimal mode is swept over every valid operand pair with both carry-in values for both add and subtract. This covers each digit carry and borrow, the wrap past 99 and below 00, and a full result of zero. Binary mode is swept over every first operand against a spread of second operands that includes 0x00, 0x7F, 0x80 and 0xFF. This shows signed overflow apart from unsigned carry, and the N flag apart from the sign of the unsigned difference. The decimal runs also check V against the raw binary operation, so a V taken from the corrected result shows up. Between bursts the strobe is dropped while the operands keep changing, which shows whether the outputs really hold.

// File: rtl/decadd_pkg.sv
// decadd_pkg: shared types for the add/subtract unit.
// Assumes a flag bundle ordered carry, overflow, negative, zero.
package decadd_pkg;

    // Flag bundle carried from the flag logic to the output register.
    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } flags_t;

    localparam int DIGIT_BITS = 4;

endpackage

// File: rtl/decadd_digit.sv
// decadd_digit: one packed-BCD digit slice.
// Adds or subtracts one decimal digit with a carry that uses the
// "1 = carry out / no borrow" sense in both directions. Corrects the
// binary nibble result back into 0..9.
// Assumes both digits are in 0..9; other codes give an unspecified digit.
module decadd_digit
    import decadd_pkg::*;
(
    input  logic [DIGIT_BITS-1:0] a_dig,
    input  logic [DIGIT_BITS-1:0] b_dig,
    input  logic                  c_in,
    input  logic                  sub,
    output logic [DIGIT_BITS-1:0] r_dig,
    output logic                  c_out
);

    logic [DIGIT_BITS-1:0] b_eff;
    logic [DIGIT_BITS:0]   raw;

    // Form the nibble sum; subtraction uses the inverted digit.
    always_comb begin
        b_eff = sub ? ~b_dig : b_dig;
        raw   = {1'b0, a_dig} + {1'b0, b_eff} + {{DIGIT_BITS{1'b0}}, c_in};
    end

    // Correct the nibble: add 6 above nine, take 6 off on a borrow.
    always_comb begin
        if (!sub) begin
            if (raw > 5'd9) begin
                r_dig = raw[DIGIT_BITS-1:0] + 4'd6;
                c_out = 1'b1;
            end else begin
                r_dig = raw[DIGIT_BITS-1:0];
                c_out = 1'b0;
            end
        end else begin
            c_out = raw[DIGIT_BITS];
            if (!raw[DIGIT_BITS]) begin
                r_dig = raw[DIGIT_BITS-1:0] - 4'd6;
            end else begin
                r_dig = raw[DIGIT_BITS-1:0];
            end
        end
    end

endmodule

// File: rtl/decadd_binary.sv
// decadd_binary: two's-complement adder/subtractor of width W.
// Produces the raw result, the ninth-bit carry (no-borrow on subtract)
// and signed overflow. Assumes subtract is A + ~B + carry_in.
module decadd_binary #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         c_in,
    input  logic         sub,
    output logic [W-1:0] r,
    output logic         c_out,
    output logic         v_out
);

    logic [W-1:0] b_eff;
    logic [W:0]   full;

    // One wide add covers both directions.
    always_comb begin
        b_eff = sub ? ~b : b;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_in};
        r     = full[W-1:0];
        c_out = full[W];
    end

    // Overflow: same-signed addends whose result changed sign.
    always_comb begin
        v_out = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
    end

endmodule

// File: rtl/decadd_flags.sv
// decadd_flags: chooses between the binary and decimal results and
// derives N and Z from the chosen, final result. V always comes from
// the binary path; the carry comes from whichever path is selected.
module decadd_flags
    import decadd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         dec,
    input  logic [W-1:0] bin_r,
    input  logic         bin_c,
    input  logic         bin_v,
    input  logic [W-1:0] dec_r,
    input  logic         dec_c,
    output logic [W-1:0] res,
    output flags_t       flg
);

    // Select the mode's result and build the flag bundle from it.
    always_comb begin
        res   = dec ? dec_r : bin_r;
        flg.c = dec ? dec_c : bin_c;
        flg.v = bin_v;
        flg.n = res[W-1];
        flg.z = (res == '0);
    end

endmodule

// File: rtl/decadd_unit.sv
// decadd_unit: registered add/subtract unit, binary or packed BCD.
// A strobed operation is computed in one cycle and registered, so the
// result and flags appear one clock after in_valid and hold until the
// next strobe. Synchronous active-low reset clears all outputs.
// Assumes decimal operands are valid BCD; no check is made.
module decadd_unit
    import decadd_pkg::*;
#(
    parameter int NDIG = 2,
    localparam int W = NDIG * DIGIT_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    input  logic         subtract,
    input  logic         decimal,
    output logic         out_valid,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         v_out,
    output logic         n_out,
    output logic         z_out
);

    logic [W-1:0] bin_r;
    logic         bin_c;
    logic         bin_v;
    logic [W-1:0] dec_r;
    logic [NDIG:0] dchain;
    logic [W-1:0] res;
    flags_t       flg;

    // Binary path, also the source of V in both modes.
    decadd_binary #(.W(W)) u_bin (
        .a     (op_a),
        .b     (op_b),
        .c_in  (carry_in),
        .sub   (subtract),
        .r     (bin_r),
        .c_out (bin_c),
        .v_out (bin_v)
    );

    assign dchain[0] = carry_in;

    // Decimal path: a ripple of digit slices, lowest digit first.
    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        decadd_digit u_dig (
            .a_dig (op_a[g*DIGIT_BITS +: DIGIT_BITS]),
            .b_dig (op_b[g*DIGIT_BITS +: DIGIT_BITS]),
            .c_in  (dchain[g]),
            .sub   (subtract),
            .r_dig (dec_r[g*DIGIT_BITS +: DIGIT_BITS]),
            .c_out (dchain[g+1])
        );
    end

    decadd_flags #(.W(W)) u_flg (
        .dec   (decimal),
        .bin_r (bin_r),
        .bin_c (bin_c),
        .bin_v (bin_v),
        .dec_r (dec_r),
        .dec_c (dchain[NDIG]),
        .res   (res),
        .flg   (flg)
    );

    // Output register: load on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum       <= '0;
            c_out     <= 1'b0;
            v_out     <= 1'b0;
            n_out     <= 1'b0;
            z_out     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum   <= res;
                c_out <= flg.c;
                v_out <= flg.v;
                n_out <= flg.n;
                z_out <= flg.z;
            end
        end
    end

endmodule

// File: rtl/decadd_unit_chk.sv
// decadd_unit_chk: temporal checks on the unit's ports, bound to it.
module decadd_unit_chk #(
    parameter int NDIG = 2,
    localparam int W = NDIG * 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         carry_in,
    input logic         subtract,
    input logic         decimal,
    input logic         out_valid,
    input logic [W-1:0] sum,
    input logic         c_out,
    input logic         v_out,
    input logic         n_out,
    input logic         z_out
);

    function automatic logic bcd_ok(input logic [W-1:0] x);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < W / 4; i++) begin
            if (x[i*4 +: 4] > 4'd9) ok = 1'b0;
        end
        return ok;
    endfunction

    // R2: a strobe yields an output strobe one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no strobe, so nothing moves
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(sum) && $stable(c_out) &&
                       $stable(v_out) && $stable(n_out) && $stable(z_out)));

    // R3: binary add yields the nine-bit sum
    a_r3_bin_add: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !subtract && !decimal) |=>
        ({c_out, sum} == $past({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, carry_in})));

    // R6: N and Z can never both be set
    a_r6_nz_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(n_out && z_out));

    // R9: valid decimal operands yield valid decimal digits
    a_r9_dec_digits: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && decimal && bcd_ok(op_a) && bcd_ok(op_b)) |=> bcd_ok(sum));

endmodule

bind decadd_unit decadd_unit_chk #(.NDIG(NDIG)) u_chk (.*);

// File: tb/decadd_unit_bench.sv
// decadd_unit_bench: sweeps both modes and compares against arithmetic.
module decadd_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] op_a = 8'h00;
    logic [7:0] op_b = 8'h00;
    logic       carry_in = 1'b0;
    logic       subtract = 1'b0;
    logic       decimal = 1'b0;
    logic       out_valid;
    logic [7:0] sum;
    logic       c_out, v_out, n_out, z_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    decadd_unit u_decadd_unit (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int to_bcd(input int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    // Drive one strobed operation and check it after the register.
    task automatic run_op(input int a, input int b, input int ci, input int sb, input int dc);
        int s, r, cexp, sv, vexp, da, db;
        string tg;
        @(negedge clk);
        op_a = a[7:0]; op_b = b[7:0]; carry_in = ci[0];
        subtract = sb[0]; decimal = dc[0]; in_valid = 1'b1;
        sv = sb ? ($signed(a[7:0]) - $signed(b[7:0]) - (1 - ci))
                : ($signed(a[7:0]) + $signed(b[7:0]) + ci);
        vexp = (sv > 127 || sv < -128) ? 1 : 0;
        if (!dc) begin
            s    = sb ? (a - b - (1 - ci)) : (a + b + ci);
            cexp = sb ? (s >= 0) : (s > 255);
            r    = s & 255;
            tg   = sb ? "R4" : "R3";
        end else begin
            da   = (a >> 4) * 10 + (a & 15);
            db   = (b >> 4) * 10 + (b & 15);
            s    = sb ? (da - db - (1 - ci)) : (da + db + ci);
            cexp = sb ? (s >= 0) : (s > 99);
            r    = to_bcd(((s % 100) + 100) % 100);
            tg   = sb ? "R8" : "R7";
        end
        @(negedge clk);
        chk({tg, " sum"}, sum, r);
        chk({tg, " carry"}, c_out, cexp);
        chk("R5 overflow", v_out, vexp);
        chk("R6 negative", n_out, (r >> 7) & 1);
        chk("R6 zero", z_out, (r == 0));
        chk("R2 out_valid", out_valid, 1);
    endtask

    // Drop the strobe, wiggle inputs, confirm the outputs hold.
    task automatic idle_check();
        logic [7:0] keep_s;
        logic [3:0] keep_f;
        @(negedge clk);
        keep_s = sum; keep_f = {c_out, v_out, n_out, z_out};
        in_valid = 1'b0; op_a = ~op_a; op_b = op_b + 8'h33;
        carry_in = ~carry_in; decimal = ~decimal;
        @(negedge clk);
        chk("R2 hold out_valid", out_valid, 0);
        chk("R2 hold sum", sum, keep_s);
        chk("R2 hold flags", {c_out, v_out, n_out, z_out}, keep_f);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", out_valid, 0);
        chk("R1 reset sum", sum, 0);
        chk("R1 reset flags", {c_out, v_out, n_out, z_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {out_valid, sum, c_out, v_out, n_out, z_out}, 0);

        // Named corner cases
        run_op(8'h55, 8'h27, 0, 0, 1);   // R7: 0x82
        chk("R7 55+27", sum, 8'h82);
        run_op(8'h99, 8'h01, 0, 0, 1);   // R7: 0x00, C=1
        chk("R7 99+01 carry", {c_out, sum}, 9'h100);
        run_op(8'h02, 8'h85, 1, 1, 0);   // R6: 0x7D, N=0
        chk("R6 02-85", {n_out, sum}, 9'h07D);
        idle_check();

        // Decimal sweep: all valid operand pairs
        for (int sb = 0; sb < 2; sb++)
            for (int ci = 0; ci < 2; ci++)
                for (int x = 0; x < 100; x++) begin
                    for (int y = 0; y < 100; y++)
                        run_op(to_bcd(x), to_bcd(y), ci, sb, 1);
                    if (x % 25 == 0) idle_check();
                end

        // Binary sweep: every A against a spread of B
        for (int sb = 0; sb < 2; sb++)
            for (int ci = 0; ci < 2; ci++)
                for (int a = 0; a < 256; a++) begin
                    for (int b = 0; b < 256; b += 5) run_op(a, b, ci, sb, 0);
                    run_op(a, 8'h7F, ci, sb, 0);
                    run_op(a, 8'h80, ci, sb, 0);
                    run_op(a, 8'hFF, ci, sb, 0);
                    if (a % 64 == 0) idle_check();
                end

        in_valid = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_950_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule